// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the class, function and destination fields of an instruction from a reduced 32-bit load/store processor into the control word of a single-cycle datapath. It handles three instruction classes (data-processing, memory and branch) and drives register-file write, memory write, the result multiplexer, the ALU second-operand and immediate-extension selects, the register read-address selects, the ALU operation, a two-bit flag-update request and a next-PC request.

The decoder is purely combinational. It has no clock and no state, so its outputs follow its inputs within the same cycle. It produces raw requests only. A separate condition unit takes `reg_write`, `mem_write`, `flag_write` and `pc_src` and suppresses them when the instruction's condition fails. The design has three parts: a main decoder for the instruction class, an ALU decoder for the operation and flag request, and PC logic that combines the branch class with writes to the program-counter register.

The instruction fields are laid out as follows:
- `op_class`: 0 is data-processing, 1 is memory, 2 is branch, and 3 is reserved.
- `funct[5]`: the immediate flag.
- `funct[4:1]`: the command.
- `funct[0]`: the S bit for data-processing instructions, or the load bit for memory instructions.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: `reg_write` is 1 for a supported data-processing instruction and for a load (memory class, funct[0]=1). `mem_write` is 1 only for a store (memory class, funct[0]=0). `mem_to_reg` is 1 only for a load. A branch writes no register and no memory.
- R2: `alu_src` is 1 (immediate) for memory and branch instructions. For data-processing instructions `alu_src` equals funct[5]. `imm_src` is 0 for data-processing (8-bit rotated), 1 for memory (12-bit) and 2 for branch (24-bit). `imm_src` is 0 for the reserved class.
- R3: `reg_src` is 2'b01 for a branch, where bit 0 reads the PC as the first operand. It is 2'b10 for a store, where bit 1 reads the destination field as the second address. It is 0 otherwise.
- R4: For data-processing instructions, `alu_ctl` decodes the command funct[4:1] as follows: 0100 gives ADD (0), 0010 gives SUB (1), 0000 gives AND (2) and 1100 gives ORR (3).
- R5: Memory and branch instructions force `alu_ctl` to ADD (0), whatever the command bits hold.
- R6: `flag_write` is nonzero only for a supported data-processing instruction with funct[0]=1. Bit 1 requests the N/Z update. Bit 0 requests the C/V update and is set only for ADD and SUB.
- R7: `pc_src` is 1 for every branch instruction.
- R8: `pc_src` is 1 when `reg_write` is 1 and `rd` is 15. A store or an unsupported instruction with `rd`=15 does not raise it.
- R9: The reserved class, and data-processing commands other than the four listed, drive `reg_write`, `mem_write`, `mem_to_reg`, `flag_write` and `pc_src` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Instruction class field |
| funct | input | 6 | Immediate flag, command and S/load bit |
| rd | input | 4 | Destination register index |
| reg_write | output | 1 | Register-file write request |
| mem_write | output | 1 | Data-memory write request |
| mem_to_reg | output | 1 | Select memory read data as result |
| alu_src | output | 1 | Select immediate as ALU operand B |
| imm_src | output | 2 | Immediate extension format |
| reg_src | output | 2 | Register read-address selects |
| alu_ctl | output | 2 | ALU operation: ADD, SUB, AND, ORR |
| flag_write | output | 2 | Flag-update request: bit 1 N/Z, bit 0 C/V |
| pc_src | output | 1 | Next-PC-from-result request |

## Verification
Every output is combinational, so each result is due in the same cycle as the fields that produce it, with no register in between. The bench applies a new field combination on the rising edge of its clock and compares all outputs on the following falling edge, half a period later, after the decoder has settled. It sweeps every class, function and destination value, 4096 combinations in all, against a model computed from the field rules.

// File: rtl/icd_pkg.sv
package icd_pkg;
  parameter int unsigned CLS_W   = 2;
  parameter int unsigned FUNCT_W = 6;
  parameter int unsigned RIDX_W  = 4;
  parameter int unsigned ALU_W   = 2;
  parameter int unsigned IMM_W   = 2;
  parameter int unsigned FLAG_W  = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_DATA = 2'd0,
    CLS_MEM  = 2'd1,
    CLS_JUMP = 2'd2,
    CLS_RSV  = 2'd3
  } cls_e;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_ORR = 2'd3
  } alu_op_e;

  typedef enum logic [IMM_W-1:0] {
    IMM_ROT8  = 2'd0,
    IMM_OFF12 = 2'd1,
    IMM_JMP24 = 2'd2
  } imm_fmt_e;

  localparam logic [3:0] CMD_AND = 4'b0000;
  localparam logic [3:0] CMD_SUB = 4'b0010;
  localparam logic [3:0] CMD_ADD = 4'b0100;
  localparam logic [3:0] CMD_ORR = 4'b1100;
endpackage

// File: rtl/icd_alu_dec.sv
module icd_alu_dec
  import icd_pkg::*;
#(
  parameter int unsigned FW = FUNCT_W
) (
  input  logic [CLS_W-1:0]  op_class,
  input  logic [FW-1:0]     funct,
  output logic              cmd_ok,
  output logic [ALU_W-1:0]  alu_ctl,
  output logic [FLAG_W-1:0] flag_write
);
  localparam int unsigned CMD_HI = FW - 2;
  localparam int unsigned CMD_LO = 1;

  logic [CMD_HI-CMD_LO:0] cmd;
  logic                   s_bit;
  alu_op_e                dp_op;
  logic                   arith;

  assign cmd   = funct[CMD_HI:CMD_LO];
  assign s_bit = funct[0];

  always_comb begin
    cmd_ok = 1'b1;
    dp_op  = ALU_ADD;
    unique case (cmd)
      CMD_ADD: dp_op = ALU_ADD;
      CMD_SUB: dp_op = ALU_SUB;
      CMD_AND: dp_op = ALU_AND;
      CMD_ORR: dp_op = ALU_ORR;
      default: cmd_ok = 1'b0;
    endcase
  end

  assign arith = (dp_op == ALU_ADD) || (dp_op == ALU_SUB);

  always_comb begin
    alu_ctl    = ALU_ADD;
    flag_write = '0;
    if (cls_e'(op_class) == CLS_DATA && cmd_ok) begin
      alu_ctl = dp_op;
      if (s_bit) flag_write = {1'b1, arith};
    end
  end

  always_comb begin
    assert_cv_needs_nz_R6: assert (!(flag_write[0] && !flag_write[1]));
  end
endmodule

// File: rtl/icd_main_dec.sv
module icd_main_dec
  import icd_pkg::*;
#(
  parameter int unsigned FW = FUNCT_W
) (
  input  logic [CLS_W-1:0] op_class,
  input  logic [FW-1:0]    funct,
  input  logic             cmd_ok,
  output logic             is_jump,
  output logic             reg_write,
  output logic             mem_write,
  output logic             mem_to_reg,
  output logic             alu_src,
  output logic [IMM_W-1:0] imm_src,
  output logic [1:0]       reg_src
);
  localparam int unsigned IMM_BIT = FW - 1;

  logic ld_bit;
  assign ld_bit = funct[0];

  always_comb begin
    is_jump    = 1'b0;
    reg_write  = 1'b0;
    mem_write  = 1'b0;
    mem_to_reg = 1'b0;
    alu_src    = 1'b0;
    imm_src    = IMM_ROT8;
    reg_src    = 2'b00;
    unique case (cls_e'(op_class))
      CLS_DATA: begin
        reg_write = cmd_ok;
        alu_src   = funct[IMM_BIT];
      end
      CLS_MEM: begin
        alu_src    = 1'b1;
        imm_src    = IMM_OFF12;
        reg_write  = ld_bit;
        mem_to_reg = ld_bit;
        mem_write  = !ld_bit;
        reg_src    = ld_bit ? 2'b00 : 2'b10;
      end
      CLS_JUMP: begin
        is_jump = 1'b1;
        alu_src = 1'b1;
        imm_src = IMM_JMP24;
        reg_src = 2'b01;
      end
      default: ;
    endcase
  end

  always_comb begin
    assert_single_write_R1: assert (!(reg_write && mem_write));
  end
endmodule

// File: rtl/icd_pc_logic.sv
module icd_pc_logic
  import icd_pkg::*;
#(
  parameter int unsigned AW = RIDX_W
) (
  input  logic          is_jump,
  input  logic          reg_write,
  input  logic [AW-1:0] rd,
  output logic          pc_src
);
  localparam logic [AW-1:0] PC_IDX = {AW{1'b1}};

  logic hits_pc;
  assign hits_pc = (rd == PC_IDX);
  assign pc_src  = is_jump || (reg_write && hits_pc);

  always_comb begin
    assert_pc_write_R8: assert (!(reg_write && rd == PC_IDX) || pc_src);
  end
endmodule

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder
  import icd_pkg::*;
#(
  parameter int unsigned FW = FUNCT_W,
  parameter int unsigned AW = RIDX_W
) (
  input  logic [CLS_W-1:0]  op_class,
  input  logic [FW-1:0]     funct,
  input  logic [AW-1:0]     rd,
  output logic              reg_write,
  output logic              mem_write,
  output logic              mem_to_reg,
  output logic              alu_src,
  output logic [IMM_W-1:0]  imm_src,
  output logic [1:0]        reg_src,
  output logic [ALU_W-1:0]  alu_ctl,
  output logic [FLAG_W-1:0] flag_write,
  output logic              pc_src
);
  logic cmd_ok;
  logic is_jump;

  icd_alu_dec #(.FW(FW)) alu_dec_i (
    .op_class   (op_class),
    .funct      (funct),
    .cmd_ok     (cmd_ok),
    .alu_ctl    (alu_ctl),
    .flag_write (flag_write)
  );

  icd_main_dec #(.FW(FW)) main_dec_i (
    .op_class   (op_class),
    .funct      (funct),
    .cmd_ok     (cmd_ok),
    .is_jump    (is_jump),
    .reg_write  (reg_write),
    .mem_write  (mem_write),
    .mem_to_reg (mem_to_reg),
    .alu_src    (alu_src),
    .imm_src    (imm_src),
    .reg_src    (reg_src)
  );

  icd_pc_logic #(.AW(AW)) pc_logic_i (
    .is_jump   (is_jump),
    .reg_write (reg_write),
    .rd        (rd),
    .pc_src    (pc_src)
  );

  always_comb begin
    assert_jump_redirect_R7: assert (cls_e'(op_class) != CLS_JUMP || pc_src);
    assert_addr_add_R5: assert (!(cls_e'(op_class) == CLS_MEM || cls_e'(op_class) == CLS_JUMP)
                                || alu_ctl == ALU_ADD);
    assert_flags_only_dp_R6: assert (flag_write == '0
                                     || (cls_e'(op_class) == CLS_DATA && funct[0]));
    assert_rsv_quiet_R9: assert (cls_e'(op_class) != CLS_RSV
                                 || !(reg_write || mem_write || mem_to_reg || pc_src
                                      || flag_write != '0));
  end
endmodule

// File: tb/instr_ctrl_decoder_tb_top.sv
module instr_ctrl_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [1:0] op_class = '0;
  logic [5:0] funct    = '0;
  logic [3:0] rd       = '0;
  logic       reg_write, mem_write, mem_to_reg, alu_src, pc_src;
  logic [1:0] imm_src, reg_src, alu_ctl, flag_write;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  instr_ctrl_decoder dut_i (
    .op_class(op_class), .funct(funct), .rd(rd),
    .reg_write(reg_write), .mem_write(mem_write), .mem_to_reg(mem_to_reg),
    .alu_src(alu_src), .imm_src(imm_src), .reg_src(reg_src),
    .alu_ctl(alu_ctl), .flag_write(flag_write), .pc_src(pc_src)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cls=%0d funct=%b rd=%0d)",
               req, what, act, exp, op_class, funct, rd);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset-state check: all-zero fields decode as AND register, no S
    chk("R4", "alu_ctl@zero", int'(alu_ctl), 2);
    chk("R1", "reg_write@zero", int'(reg_write), 1);
    chk("R6", "flag_write@zero", int'(flag_write), 0);
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 64; f++) begin
        for (int r = 0; r < 16; r++) begin
          int cmd, e_op, e_rw, e_mw, e_mr, e_as, e_is, e_rs, e_fw, e_pc;
          bit ok, ld;
          @(posedge clk);
          op_class = 2'(c); funct = 6'(f); rd = 4'(r);
          cmd = (f >> 1) & 15;
          ld  = f[0];
          ok  = (cmd == 4) || (cmd == 2) || (cmd == 0) || (cmd == 12);
          e_op = 0; e_rw = 0; e_mw = 0; e_mr = 0; e_as = 0;
          e_is = 0; e_rs = 0; e_fw = 0;
          case (c)
            0: begin
              e_as = (f >> 5) & 1;
              if (ok) begin
                e_rw = 1;
                e_op = (cmd == 4) ? 0 : (cmd == 2) ? 1 : (cmd == 0) ? 2 : 3;
                if (ld) e_fw = 2 + ((e_op < 2) ? 1 : 0);
              end
            end
            1: begin
              e_as = 1; e_is = 1;
              e_rw = ld; e_mr = ld; e_mw = !ld; e_rs = ld ? 0 : 2;
            end
            2: begin e_as = 1; e_is = 2; e_rs = 1; end
            default: ;
          endcase
          e_pc = (c == 2) || (e_rw == 1 && r == 15);
          @(negedge clk);
          chk(c == 3 || (c == 0 && !ok) ? "R9" : "R1", "reg_write", int'(reg_write), e_rw);
          chk("R1", "mem_write", int'(mem_write), e_mw);
          chk("R1", "mem_to_reg", int'(mem_to_reg), e_mr);
          chk("R2", "alu_src", int'(alu_src), e_as);
          chk("R2", "imm_src", int'(imm_src), e_is);
          chk("R3", "reg_src", int'(reg_src), e_rs);
          chk(c == 0 ? "R4" : "R5", "alu_ctl", int'(alu_ctl), e_op);
          chk("R6", "flag_write", int'(flag_write), e_fw);
          chk(c == 2 ? "R7" : "R8", "pc_src", int'(pc_src), e_pc);
        end
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule